// File: doc/BRIEF.md
# Destination MAC Address Hash Filter

This block decides whether a destination MAC address belongs to a table of accepted stations. The table has 2048 slots and uses open addressing. A 48-bit address is turned into an 11-bit home slot by a fixed bit-shuffling hash. The block then walks forward through consecutive slots, one slot per clock. The walk stops at an empty slot, at a slot holding the same address, or once a fixed number of slots has been visited. The walk wraps from the last slot back to slot 0.

A lookup reports hit or miss. On a hit it also reports the two per-entry attributes: a skip flag and a receive-discard flag. It gives the slot where the walk ended in every case.

A host port adds and removes addresses using the same walk, so that entries always sit where a lookup will find them. Only one operation runs at a time. Requests are taken only while the block is idle. If a lookup and a host request arrive in the same cycle, the lookup is taken.

Top module: `mac_hash_filter`

## Requirements
- R1: The home slot of address M is computed as follows. Split M into H = M[47:32] and L = M[31:0]. Reverse the bit order inside every byte of both parts. Then take a = L[7:2], b = {L[14:8], L[1:0]}, c = L[23:15] and d = {H[0], L[31:24]}. The home slot is the low 11 bits of ({a, 9'b0} | (b ^ c ^ d)). A lookup in an empty table ends after one probe, with `slot_idx` equal to the home slot.
- R2: Each probe after the first visits the slot one above the previous one. Slot 0x7FF is followed by slot 0x000.
- R3: A lookup that finds its address reports `lk_hit`=1 and `lk_miss`=0. It also reports the entry's stored skip and discard flags on `lk_skip` and `lk_discard`, and gives the entry's slot on `slot_idx`.
- R4: Two entries match only when all 48 address bits are equal; the attribute bits take no part in the match. Adding an address that is already present rewrites its own slot with the new attributes.
- R5: A lookup ends with `lk_miss`=1 and `lk_hit`=0 in two cases. The first is reaching an empty slot, which is then reported on `slot_idx`. The second is visiting HOPS slots (default 12) without a match, in which case the last slot visited is reported.
- R6: An add writes to the first slot on the walk that is empty or holds the same address, and reports that slot. If HOPS slots are visited without finding one, the add changes nothing and reports `hs_full`=1.
- R7: A delete (`hs_del`=1) empties the slot that holds the address. A delete of an address that is not found leaves the table unchanged.
- R8: Requests are taken only while `busy`=0. When `lk_req` and `hs_req` are both high in the same cycle, only the lookup runs. A host request raised while `busy`=1 is ignored and produces no `hs_done`.
- R9: After reset the table is empty, and `busy`, `lk_done` and `hs_done` are low.
- R10: An operation that visits k slots raises its done flag (`lk_done` or `hs_done`) at the k-th clock edge after the edge that takes the request. The done flag is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Start a lookup of `lk_mac` |
| lk_mac | input | 48 | Destination address to look up |
| hs_req | input | 1 | Start a host add or delete |
| hs_del | input | 1 | 1 = delete, 0 = add |
| hs_mac | input | 48 | Address to add or delete |
| hs_skip | input | 1 | Skip flag stored with an add |
| hs_discard | input | 1 | Receive-discard flag stored with an add |
| busy | output | 1 | An operation is in progress |
| lk_done | output | 1 | One-cycle pulse: lookup finished |
| lk_hit | output | 1 | Lookup found the address |
| lk_miss | output | 1 | Lookup did not find the address |
| lk_skip | output | 1 | Skip flag of the matched entry |
| lk_discard | output | 1 | Discard flag of the matched entry |
| hs_done | output | 1 | One-cycle pulse: host operation finished |
| hs_full | output | 1 | Add failed because the walk was exhausted |
| slot_idx | output | 11 | Slot where the last operation ended |

## Verification
The hash is checked first, by looking up all 48 walking-one addresses and a set of mixed patterns in an empty table. Each of these isolates which address bits reach which slot bits, and in what bit order.

Next, thirteen addresses that share home slot 0x7FA are built into a chain. The chain separates the wrap at 0x7FF, the hop limit on both lookup and add, and rewriting an existing entry. It also shows how a hole left by a delete cuts the walk short.

Finally, a lookup and an add are raised together, and an add is raised during a long lookup. These two cases show whether arbitration and the idle-only acceptance rule let a host write slip through.

// File: rtl/mhf_pkg.sv
// Package: shared constants and types of the MAC hash filter.
// Assumes a 48-bit MAC and an 11-bit slot index (fixed by the hash).
package mhf_pkg;
    localparam int MAC_W  = 48;
    localparam int IDX_W  = 11;
    localparam int WORD_W = 32;

    // Low-word control bit positions
    localparam int BIT_VALID   = 0;
    localparam int BIT_SKIP    = 1;
    localparam int BIT_DISCARD = 2;
    localparam int CTRL_W      = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PROBE = 1'b1
    } fsm_t;

    typedef enum logic [1:0] {
        OP_LOOK = 2'd0,
        OP_ADD  = 2'd1,
        OP_DEL  = 2'd2
    } op_t;
endpackage

// File: rtl/mhf_hash.sv
// Module: mhf_hash
// Computes the 11-bit home slot of a 48-bit MAC address. Every byte is
// first bit-reversed (nibble swap followed by a per-nibble reversal). The
// result is then folded: three 9-bit slices are XORed, and a 6-bit slice
// sits above them before truncation to 11 bits.
// Assumes: purely combinational; the caller registers the result.
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [MAC_W-1:0] mac,
    output logic [IDX_W-1:0] home
);
    localparam int NBYTES = MAC_W / 8;
    localparam int FOLD_W = 9;
    localparam int TOP_W  = 6;

    logic [MAC_W-1:0]       proc;
    logic [WORD_W-1:0]      lo_p;
    logic [15:0]            hi_p;
    logic [TOP_W-1:0]       s_top;
    logic [FOLD_W-1:0]      s_b;
    logic [FOLD_W-1:0]      s_c;
    logic [FOLD_W-1:0]      s_d;
    logic [TOP_W+FOLD_W-1:0] wide;
    logic                   unused_hash;

    // Bit-reverse each byte of the address
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        for (genvar j = 0; j < 8; j++) begin : g_bit
            assign proc[8*g + j] = mac[8*g + 7 - j];
        end
    end

    // Split into the processed high and low parts
    assign lo_p = proc[WORD_W-1:0];
    assign hi_p = proc[MAC_W-1:WORD_W];

    // Form the slices and fold them into the index
    always_comb begin
        s_top = lo_p[7:2];
        s_b   = {lo_p[14:8], lo_p[1:0]};
        s_c   = lo_p[23:15];
        s_d   = {hi_p[0], lo_p[31:24]};
        wide  = {s_top, {FOLD_W{1'b0}}} | {{TOP_W{1'b0}}, (s_b ^ s_c ^ s_d)};
        home  = wide[IDX_W-1:0];
    end

    assign unused_hash = ^{hi_p[15:1], wide[TOP_W+FOLD_W-1:IDX_W]};
endmodule

// File: rtl/mhf_entry_codec.sv
// Module: mhf_entry_codec
// Packs a key and its attributes into the two 32-bit words of a table
// entry. It also compares a stored entry with the key and extracts the
// stored attributes. Low word: valid, skip and discard in the three
// lowest bits, address bits [28:0] above them. High word: address bits
// [47:29] at the bottom, zero above.
// Assumes: the compare ignores the three control bits of the low word.
module mhf_entry_codec
    import mhf_pkg::*;
(
    input  logic [MAC_W-1:0]  key,
    input  logic              key_skip,
    input  logic              key_disc,
    input  logic [WORD_W-1:0] st_lo,
    input  logic [WORD_W-1:0] st_hi,
    output logic [WORD_W-1:0] enc_lo,
    output logic [WORD_W-1:0] enc_hi,
    output logic              match,
    output logic              st_skip,
    output logic              st_disc
);
    localparam int LO_ADDR = WORD_W - CTRL_W;
    localparam int HI_ADDR = MAC_W - LO_ADDR;

    logic unused_codec;

    // Build the two words of a new entry
    always_comb begin
        enc_lo = {key[LO_ADDR-1:0], key_disc, key_skip, 1'b1};
        enc_hi = {{(WORD_W-HI_ADDR){1'b0}}, key[MAC_W-1:LO_ADDR]};
    end

    // Compare the address fields and pull out the attributes
    always_comb begin
        match   = (st_lo[WORD_W-1:CTRL_W] == enc_lo[WORD_W-1:CTRL_W]) &&
                  (st_hi == enc_hi);
        st_skip = st_lo[BIT_SKIP];
        st_disc = st_lo[BIT_DISCARD];
    end

    assign unused_codec = st_lo[BIT_VALID];
endmodule

// File: rtl/mhf_table.sv
// Module: mhf_table
// The address table: two word arrays with combinational read, plus a
// per-slot valid flag that reset clears. A slot counts as occupied only
// when both its valid flag and the valid bit of its low word are set.
// Assumes: one write per cycle; a clear writes both words to zero.
module mhf_table
    import mhf_pkg::*;
#(
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi,
    input  logic              we,
    input  logic              wr_set,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_lo,
    input  logic [WORD_W-1:0] wr_hi
);
    logic [WORD_W-1:0] lo_mem [DEPTH];
    logic [WORD_W-1:0] hi_mem [DEPTH];
    logic [DEPTH-1:0]  valid_q;

    // Read port
    always_comb begin
        rd_lo    = lo_mem[rd_idx];
        rd_hi    = hi_mem[rd_idx];
        rd_valid = valid_q[rd_idx] & rd_lo[BIT_VALID];
    end

    // Word storage, no reset
    always_ff @(posedge clk) begin
        if (we) begin
            lo_mem[wr_idx] <= wr_set ? wr_lo : '0;
            hi_mem[wr_idx] <= wr_set ? wr_hi : '0;
        end
    end

    // Valid flags, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[wr_idx] <= wr_set;
        end
    end

    // R7: a clear leaves the slot invalid
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr_set) |=> !valid_q[$past(wr_idx)]);
    // R6: a set makes the slot valid
    p_set_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_set) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/mac_hash_filter.sv
// Module: mac_hash_filter
// Top level of the MAC hash filter. It takes a lookup or host request
// while idle, hashes the address to a home slot, then probes one slot
// per cycle. Probing wraps at the table end and stops on an empty slot,
// a matching slot, or the HOPS-th visit. Lookups report hit or miss and
// the entry's attributes; adds and deletes update the slot where the
// walk stopped.
// Assumes: requesters hold nothing; a request is seen only while idle.
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int HOPS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [MAC_W-1:0] lk_mac,
    input  logic             hs_req,
    input  logic             hs_del,
    input  logic [MAC_W-1:0] hs_mac,
    input  logic             hs_skip,
    input  logic             hs_discard,
    output logic             busy,
    output logic             lk_done,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_skip,
    output logic             lk_discard,
    output logic             hs_done,
    output logic             hs_full,
    output logic [IDX_W-1:0] slot_idx
);
    localparam int HOP_W = $clog2(HOPS + 1);
    localparam logic [HOP_W-1:0] LAST_HOP = HOP_W'(HOPS - 1);

    fsm_t              state;
    op_t               op;
    logic [MAC_W-1:0]  key;
    logic              key_skip;
    logic              key_disc;
    logic [IDX_W-1:0]  idx;
    logic [HOP_W-1:0]  hop;

    logic [MAC_W-1:0]  in_mac;
    logic [IDX_W-1:0]  in_home;
    logic              cur_valid;
    logic [WORD_W-1:0] cur_lo;
    logic [WORD_W-1:0] cur_hi;
    logic [WORD_W-1:0] enc_lo;
    logic [WORD_W-1:0] enc_hi;
    logic              cur_match;
    logic              cur_skip;
    logic              cur_disc;
    logic              stop_empty;
    logic              stop_match;
    logic              exhausted;
    logic              stop;
    logic              we;
    logic              wr_set;

    // Pick the incoming address; the lookup wins over the host
    assign in_mac = lk_req ? lk_mac : hs_mac;

    mhf_hash u_hash (
        .mac  (in_mac),
        .home (in_home)
    );

    mhf_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (cur_valid),
        .rd_lo    (cur_lo),
        .rd_hi    (cur_hi),
        .we       (we),
        .wr_set   (wr_set),
        .wr_idx   (idx),
        .wr_lo    (enc_lo),
        .wr_hi    (enc_hi)
    );

    mhf_entry_codec u_codec (
        .key      (key),
        .key_skip (key_skip),
        .key_disc (key_disc),
        .st_lo    (cur_lo),
        .st_hi    (cur_hi),
        .enc_lo   (enc_lo),
        .enc_hi   (enc_hi),
        .match    (cur_match),
        .st_skip  (cur_skip),
        .st_disc  (cur_disc)
    );

    // Decide the outcome of the current probe
    always_comb begin
        stop_empty = !cur_valid;
        stop_match = cur_valid && cur_match;
        exhausted  = !stop_empty && !stop_match && (hop == LAST_HOP);
        stop       = stop_empty || stop_match || exhausted;
    end

    // Table write control for add and delete
    always_comb begin
        we     = 1'b0;
        wr_set = 1'b0;
        if (state == ST_PROBE) begin
            if (op == OP_ADD && (stop_empty || stop_match)) begin
                we     = 1'b1;
                wr_set = 1'b1;
            end else if (op == OP_DEL && stop_match) begin
                we = 1'b1;
            end
        end
    end

    assign busy = (state == ST_PROBE);

    // Probe state machine and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op         <= OP_LOOK;
            key        <= '0;
            key_skip   <= 1'b0;
            key_disc   <= 1'b0;
            idx        <= '0;
            hop        <= '0;
            lk_done    <= 1'b0;
            lk_hit     <= 1'b0;
            lk_miss    <= 1'b0;
            lk_skip    <= 1'b0;
            lk_discard <= 1'b0;
            hs_done    <= 1'b0;
            hs_full    <= 1'b0;
            slot_idx   <= '0;
        end else begin
            lk_done <= 1'b0;
            hs_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (lk_req || hs_req) begin
                        state    <= ST_PROBE;
                        key      <= in_mac;
                        idx      <= in_home;
                        hop      <= '0;
                        key_skip <= !lk_req && hs_skip;
                        key_disc <= !lk_req && hs_discard;
                        if (lk_req)      op <= OP_LOOK;
                        else if (hs_del) op <= OP_DEL;
                        else             op <= OP_ADD;
                    end
                end
                ST_PROBE: begin
                    if (stop) begin
                        state    <= ST_IDLE;
                        slot_idx <= idx;
                        if (op == OP_LOOK) begin
                            lk_done    <= 1'b1;
                            lk_hit     <= stop_match;
                            lk_miss    <= !stop_match;
                            lk_skip    <= stop_match && cur_skip;
                            lk_discard <= stop_match && cur_disc;
                        end else begin
                            hs_done <= 1'b1;
                            hs_full <= (op == OP_ADD) && exhausted;
                        end
                    end else begin
                        idx <= idx + IDX_W'(1);
                        hop <= hop + HOP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a finished lookup is exactly one of hit or miss
    p_one_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> $onehot({lk_hit, lk_miss}));
    // R5: the hop count never reaches the limit
    p_hop_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (hop < HOP_W'(HOPS)));
    // R2: consecutive probes advance by one slot, wrapping
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE && $past(state) == ST_PROBE) |->
        (idx == $past(idx) + IDX_W'(1)));
    // R10: done flags are single-cycle pulses
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done || hs_done) |=> !(lk_done || hs_done));
    // R8: only one kind of operation finishes at a time
    p_excl_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_done, hs_done}));
    // R8: a request seen while idle starts an operation
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (lk_req || hs_req)) |=> busy);
    // R6: full status only accompanies a host completion
    p_full_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_done && hs_full) |-> $past(op) == OP_ADD);
endmodule

// File: tb/mac_hash_filter_bench.sv
module mac_hash_filter_bench;
    localparam int HOPS = 12;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        hs_req = 1'b0;
    logic        hs_del = 1'b0;
    logic [47:0] hs_mac = '0;
    logic        hs_skip = 1'b0;
    logic        hs_discard = 1'b0;
    logic        busy, lk_done, lk_hit, lk_miss, lk_skip, lk_discard;
    logic        hs_done, hs_full;
    logic [10:0] slot_idx;

    int errors = 0;
    int checks = 0;

    bit          mv [DEPTH];
    logic [47:0] ma [DEPTH];
    bit          ms [DEPTH];
    bit          md [DEPTH];

    logic [47:0] chain [13];

    always #2.5 clk = ~clk;

    mac_hash_filter #(.HOPS(HOPS)) u_mac_hash_filter (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_mac(lk_mac),
        .hs_req(hs_req), .hs_del(hs_del), .hs_mac(hs_mac),
        .hs_skip(hs_skip), .hs_discard(hs_discard),
        .busy(busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_skip(lk_skip), .lk_discard(lk_discard),
        .hs_done(hs_done), .hs_full(hs_full), .slot_idx(slot_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference hash, built step by step from the R1 description
    function automatic logic [10:0] ref_hash(input logic [47:0] m);
        logic [15:0] hs;
        logic [31:0] ls;
        logic [15:0] h;
        logic [31:0] l;
        logic [14:0] r;
        hs = ((m[47:32] & 16'hF0F0) >> 4) | ((m[47:32] & 16'h0F0F) << 4);
        ls = ((m[31:0] & 32'hF0F0F0F0) >> 4) | ((m[31:0] & 32'h0F0F0F0F) << 4);
        for (int n = 0; n < 4; n++)
            for (int b = 0; b < 4; b++) h[4*n+b] = hs[4*n+3-b];
        for (int n = 0; n < 8; n++)
            for (int b = 0; b < 4; b++) l[4*n+b] = ls[4*n+3-b];
        r = {l[7:2], 9'b0} | {6'b0, ({l[14:8], l[1:0]} ^ l[23:15] ^ {h[0], l[31:24]})};
        return r[10:0];
    endfunction

    // Model walk: returns found, final slot, probes, exhausted
    task automatic model_walk(input logic [47:0] m, output bit found,
                              output logic [10:0] slot, output int probes,
                              output bit exh);
        logic [10:0] i;
        i = ref_hash(m);
        found = 0; exh = 1; probes = HOPS; slot = i;
        for (int k = 0; k < HOPS; k++) begin
            slot = i;
            if (!mv[i]) begin exh = 0; probes = k + 1; return; end
            if (ma[i] == m) begin found = 1; exh = 0; probes = k + 1; return; end
            i = i + 11'd1;
        end
    endtask

    task automatic wait_done(input bit want_lk, output int cnt, output bit other);
        cnt = 0; other = 0;
        for (int t = 0; t < 64; t++) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (want_lk ? hs_done : lk_done) other = 1;
            if (want_lk ? lk_done : hs_done) return;
        end
    endtask

    task automatic do_lookup(input logic [47:0] m, input string req);
        bit found, exh, other;
        logic [10:0] slot;
        int probes, cnt;
        model_walk(m, found, slot, probes, exh);
        @(negedge clk);
        lk_mac = m; lk_req = 1'b1;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0;
        wait_done(1'b1, cnt, other);
        chk(lk_hit == found, req, "lk_hit", lk_hit, found);
        chk(lk_miss == !found, req, "lk_miss", lk_miss, !found);
        chk(slot_idx == slot, req, "slot_idx", slot_idx, slot);
        chk(cnt == probes, "R10", "lookup latency", cnt, probes);
        if (found) begin
            chk(lk_skip == ms[slot], "R3", "lk_skip", lk_skip, ms[slot]);
            chk(lk_discard == md[slot], "R3", "lk_discard", lk_discard, md[slot]);
        end
        @(posedge clk); @(negedge clk);
        chk(lk_done == 1'b0, "R10", "done pulse width", lk_done, 0);
    endtask

    task automatic do_host(input bit del, input logic [47:0] m, input bit s,
                           input bit d, input string req);
        bit found, exh, other;
        logic [10:0] slot;
        int probes, cnt;
        model_walk(m, found, slot, probes, exh);
        @(negedge clk);
        hs_mac = m; hs_del = del; hs_skip = s; hs_discard = d; hs_req = 1'b1;
        @(posedge clk); @(negedge clk);
        hs_req = 1'b0;
        wait_done(1'b0, cnt, other);
        chk(cnt == probes, "R10", "host latency", cnt, probes);
        if (!del) begin
            chk(hs_full == exh, "R6", "hs_full", hs_full, exh);
            if (!exh) begin
                chk(slot_idx == slot, req, "add slot", slot_idx, slot);
                mv[slot] = 1; ma[slot] = m; ms[slot] = s; md[slot] = d;
            end
        end else begin
            chk(hs_full == 1'b0, "R7", "hs_full on delete", hs_full, 0);
            if (found) mv[slot] = 0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, cnt;
        bit other;
        logic [47:0] c;
        for (int i = 0; i < DEPTH; i++) mv[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(busy == 0, "R9", "busy after reset", busy, 0);
        chk(lk_done == 0, "R9", "lk_done after reset", lk_done, 0);
        chk(hs_done == 0, "R9", "hs_done after reset", hs_done, 0);

        // R1: walking ones and mixed patterns on the empty table
        for (int b = 0; b < 48; b++) do_lookup(48'd1 << b, "R1");
        do_lookup(48'h0, "R1");
        do_lookup(48'hFFFF_FFFF_FFFF, "R1");
        do_lookup(48'h0123_4567_89AB, "R1");
        do_lookup(48'hA5A5_5A5A_C33C, "R1");

        // R3: add with attributes, then look up
        do_host(0, 48'h0011_2233_4455, 1, 0, "R6");
        do_host(0, 48'h6677_8899_AABB, 0, 1, "R6");
        do_lookup(48'h0011_2233_4455, "R3");
        do_lookup(48'h6677_8899_AABB, "R3");

        // Build a chain of addresses sharing home slot 0x7FA
        n = 0;
        for (int k = 1; k < 200000 && n < 13; k++) begin
            c = {16'h02C0, 32'(k)};
            if (ref_hash(c) == 11'h7FA) begin chain[n] = c; n++; end
        end
        chk(n == 13, "R2", "chain search", n, 13);
        // R2: chain fill wraps past 0x7FF
        for (int k = 0; k < 12; k++) do_host(0, chain[k], k[0], k[1], "R2");
        do_lookup(chain[7], "R2");
        do_lookup(chain[11], "R2");
        // R6: thirteenth add finds no room
        do_host(0, chain[12], 1, 1, "R6");
        // R5: lookup exhausts the hop limit
        do_lookup(chain[12], "R5");
        // R4: re-add rewrites the same slot with new attributes
        do_host(0, chain[3], 1, 1, "R4");
        do_lookup(chain[3], "R4");
        // R4: address differing in one bit is a different entry
        do_lookup(chain[3] ^ 48'h8000_0000_0000, "R4");
        // R7: delete leaves a hole; walk stops there
        do_host(1, chain[5], 0, 0, "R7");
        do_lookup(chain[5], "R7");
        do_lookup(chain[9], "R5");
        do_host(1, 48'hDEAD_BEEF_0001, 0, 0, "R7");
        do_lookup(chain[4], "R7");
        do_lookup(48'h0011_2233_4455, "R7");
        // R6: add refills the first free slot
        do_host(0, chain[12], 0, 1, "R6");
        do_lookup(chain[12], "R6");

        // R8: simultaneous requests, lookup wins
        @(negedge clk);
        lk_mac = 48'h0011_2233_4455; lk_req = 1'b1;
        hs_mac = 48'h1234_0000_0077; hs_del = 0; hs_req = 1'b1;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0; hs_req = 1'b0;
        wait_done(1'b1, cnt, other);
        chk(other == 0, "R8", "hs_done during lookup", other, 0);
        chk(lk_hit == 1, "R8", "lookup taken", lk_hit, 1);
        do_lookup(48'h1234_0000_0077, "R8");

        // R8: host request while busy is ignored
        do_host(1, chain[5], 0, 0, "R8");
        @(negedge clk);
        lk_mac = chain[9]; lk_req = 1'b1;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(busy == 1, "R8", "busy during walk", busy, 1);
        hs_mac = 48'h4321_0000_0099; hs_del = 0; hs_req = 1'b1;
        @(posedge clk); @(negedge clk);
        hs_req = 1'b0;
        wait_done(1'b1, cnt, other);
        chk(other == 0, "R8", "hs_done while busy", other, 0);
        @(posedge clk); @(negedge clk);
        chk(hs_done == 0, "R8", "late hs_done", hs_done, 0);
        do_lookup(48'h4321_0000_0099, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule